// File: doc/BRIEF.md
# DDS Phase Engine with Quadrant Keying

This block is the phase half of a direct digital synthesizer. A 48-bit frequency word is assembled one byte at a time through a small register port. An update strobe moves it into the working copy. A 48-bit accumulator then adds the working word to itself on every clock, modulo 2^48. A 2-bit keying input adds a quarter-turn offset of 0, 90, 180 or 270 degrees. One keying bit is enough for binary phase keying, and both bits give quadrature keying. The output is the top 14 bits of the offset phase, ready for a phase-to-amplitude stage that sits outside this block.

A control register holds a feedback-enable bit. Clearing it keeps the accumulator at zero. Setting it again restarts accumulation from zero. Two instances that toggle this bit at the same time therefore leave the zero state together and stay phase-aligned. The register port is plain control: it has no handshake and never stalls. A write to the same address as an accepted write in the cycle just before is dropped, so a single address accepts at most one write every two clocks.

Top module: `dds_phase_engine`

## Requirements
- R1: A synchronous active-high reset clears the phase output, the staged tuning word, the working tuning word and the keying pipeline. It sets feedback enable to 1, so with no control write the accumulator runs as soon as the reset ends.
- R2: A write to address k, for k from 0 to 5, puts the data byte into bits 8k+7..8k of the staged tuning word. Address 0 holds the least significant byte. Staged bytes have no effect on the phase output until an update strobe.
- R3: An update strobe copies the staged word into the working word. A byte written in the same cycle as the strobe is not part of that copy; a later strobe picks it up. With no strobe, the working word holds its value.
- R4: A write whose address equals the address of the write accepted in the cycle just before is ignored. Writes to different addresses in consecutive cycles are all accepted.
- R5: On each clock with feedback enabled, the accumulator adds the working word modulo 2^48. A word of 2^34 advances the output by 1 per clock, and a word of 2^47 toggles the output between two values 0x2000 apart.
- R6: Bit 5 of the control register at address 13 is feedback enable. While it is 0 the accumulator is held at zero. After it is written back to 1, the output shows 0, 0, 0, then advances by one step per clock, counting from the clock edge where the write is taken.
- R7: The keying input adds an offset to the accumulator value: 00 adds 0, 01 adds 2^46, 10 adds 2^47 and 11 adds 3·2^46. On the output these offsets are 0x0000, 0x1000, 0x2000 and 0x3000.
- R8: The phase output is bits 47..34 of the offset phase. A keying value or accumulator value captured at clock edge n appears on the output after edge n+2.
- R9: The keying input may change as often as every second clock, and every such value appears on the output in turn with the fixed latency of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0-5 tuning bytes, 13 control) |
| wr_data | input | 8 | Register write data |
| upd | input | 1 | Copies the staged tuning word into the working word |
| phase_sel | input | 2 | Quadrant offset select for phase keying |
| phase_out | output | 14 | Offset phase, top 14 bits |

## Verification
The two functions that can land on the same clock are the byte write and the update strobe. The bench raises the strobe together with a write to a tuning byte that already holds a different staged value. It then judges the result from the output step size: the first strobe must produce the step of the earlier staged word, and only a second, lone strobe may produce the step of the new byte. A second collision is a write to the same address in two consecutive cycles. There the step size must show that the second byte was dropped.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int FTW_W     = 48;
  localparam int BYTE_W    = 8;
  localparam int OUT_W     = 14;
  localparam int SEL_W     = 2;
  localparam int ADDR_W    = 4;
  localparam int CTRL_ADDR = 13;
  localparam int FB_BIT    = 5;
endpackage

// File: rtl/dds_regfile.sv
module dds_regfile
  import dds_pkg::*;
#(
  parameter int P_FTW_W  = FTW_W,
  parameter int P_BYTE_W = BYTE_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_CTRL   = CTRL_ADDR,
  parameter int P_FB_BIT = FB_BIT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [P_ADDR_W-1:0] wr_addr,
  input  logic [P_BYTE_W-1:0] wr_data,
  input  logic                upd,
  output logic [P_FTW_W-1:0]  ftw_act,
  output logic                fb_en
);
  localparam int NBYTES = P_FTW_W / P_BYTE_W;

  logic [P_FTW_W-1:0]  staged;
  logic [P_ADDR_W-1:0] last_addr;
  logic                last_ok;
  logic                wr_ok;

  // a write repeating the address accepted one clock earlier is dropped
  assign wr_ok = wr_en && !(last_ok && (last_addr == wr_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      last_ok   <= 1'b0;
      last_addr <= '0;
    end else begin
      last_ok   <= wr_ok;
      last_addr <= wr_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
    end else if (wr_ok) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_addr == P_ADDR_W'(b))
          staged[b*P_BYTE_W +: P_BYTE_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      fb_en <= 1'b1;
    else if (wr_ok && (wr_addr == P_ADDR_W'(P_CTRL)))
      fb_en <= wr_data[P_FB_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)
      ftw_act <= '0;
    else if (upd)
      ftw_act <= staged;
  end

  // R4
  same_addr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && last_ok && (wr_addr == last_addr)) |=> ($stable(staged) && $stable(fb_en)));

  // R3
  upd_copy_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> (ftw_act == $past(staged)));

  // R3
  ftw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ftw_act));
endmodule

// File: rtl/dds_accum.sv
module dds_accum
  import dds_pkg::*;
#(
  parameter int P_FTW_W = FTW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fb_en,
  input  logic [P_FTW_W-1:0] ftw,
  output logic [P_FTW_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (fb_en)
      acc <= acc + ftw;
    else
      acc <= '0;
  end

  // R6
  fb_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !fb_en |=> (acc == '0));

  // R5
  idle_word_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_en && (ftw == '0)) |=> $stable(acc));
endmodule

// File: rtl/dds_phase_pipe.sv
module dds_phase_pipe
  import dds_pkg::*;
#(
  parameter int P_FTW_W = FTW_W,
  parameter int P_OUT_W = OUT_W,
  parameter int P_SEL_W = SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [P_FTW_W-1:0] acc,
  input  logic [P_SEL_W-1:0] phase_sel,
  output logic [P_OUT_W-1:0] phase_out
);
  localparam int PAD_W = P_OUT_W - P_SEL_W;

  logic [P_SEL_W-1:0] sel_q;
  logic [P_OUT_W-1:0] offset;
  logic [P_OUT_W-1:0] acc_top;
  logic [P_OUT_W-1:0] sum_q;
  logic [1:0]         warm;

  // quadrant offset sits on the top bits of the truncated field,
  // so low accumulator bits cannot carry into it
  assign offset  = {sel_q, {PAD_W{1'b0}}};
  assign acc_top = acc[P_FTW_W-1 -: P_OUT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      sum_q     <= '0;
      phase_out <= '0;
    end else begin
      sel_q     <= phase_sel;
      sum_q     <= acc_top + offset;
      phase_out <= sum_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      warm <= '0;
    else if (warm != 2'd3)
      warm <= warm + 2'd1;
  end

  // R8
  phase_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (phase_out == P_OUT_W'($past(acc_top, 2) + $past(offset, 2))));
endmodule

// File: rtl/dds_phase_engine.sv
module dds_phase_engine
  import dds_pkg::*;
#(
  parameter int P_FTW_W  = FTW_W,
  parameter int P_BYTE_W = BYTE_W,
  parameter int P_OUT_W  = OUT_W,
  parameter int P_SEL_W  = SEL_W,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [P_ADDR_W-1:0] wr_addr,
  input  logic [P_BYTE_W-1:0] wr_data,
  input  logic                upd,
  input  logic [P_SEL_W-1:0]  phase_sel,
  output logic [P_OUT_W-1:0]  phase_out
);
  logic [P_FTW_W-1:0] ftw_act;
  logic [P_FTW_W-1:0] acc;
  logic               fb_en;

  dds_regfile #(
    .P_FTW_W (P_FTW_W),
    .P_BYTE_W(P_BYTE_W),
    .P_ADDR_W(P_ADDR_W),
    .P_CTRL  (CTRL_ADDR),
    .P_FB_BIT(FB_BIT)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .upd    (upd),
    .ftw_act(ftw_act),
    .fb_en  (fb_en)
  );

  dds_accum #(
    .P_FTW_W(P_FTW_W)
  ) u_acc (
    .clk  (clk),
    .rst  (rst),
    .fb_en(fb_en),
    .ftw  (ftw_act),
    .acc  (acc)
  );

  dds_phase_pipe #(
    .P_FTW_W(P_FTW_W),
    .P_OUT_W(P_OUT_W),
    .P_SEL_W(P_SEL_W)
  ) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .phase_sel(phase_sel),
    .phase_out(phase_out)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (phase_out == '0));
endmodule

// File: tb/dds_phase_engine_bench.sv
`timescale 1ns/1ps
module dds_phase_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        upd = 1'b0;
  logic [1:0]  phase_sel = '0;
  logic [13:0] phase_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dds_phase_engine u_dds_phase_engine (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .upd      (upd),
    .phase_sel(phase_sel),
    .phase_out(phase_out)
  );

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_ftw(input logic [47:0] w);
    for (int i = 0; i < 6; i++) begin
      wr_en = 1'b1; wr_addr = 4'(i); wr_data = w[i*8 +: 8];
      @(negedge clk);
    end
    wr_en = 1'b0;
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_step(input logic [13:0] step, input int n, input string req);
    logic [13:0] prev;
    prev = phase_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, phase_out, prev + step);
      prev = phase_out;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 in reset", phase_out, 14'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 after reset", phase_out, 14'h0);
  endtask

  task automatic t_sel_latency();
    logic [13:0] prev;
    prev = 14'h0;
    for (int v = 1; v < 4; v++) begin
      phase_sel = 2'(v);
      @(negedge clk); chk("R8 edge n", phase_out, prev);
      @(negedge clk); chk("R8 edge n+1", phase_out, prev);
      @(negedge clk); chk("R7 offset", phase_out, 14'(v) << 12);
      prev = 14'(v) << 12;
    end
  endtask

  task automatic t_sel_rate();
    logic [1:0] hist [0:19];
    logic [1:0] seq [0:7];
    seq = '{2'd0, 2'd3, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2, 2'd1};
    for (int i = 0; i < 16; i++) begin
      phase_sel = seq[i/2];
      hist[i] = seq[i/2];
      @(negedge clk);
      if (i >= 2) chk("R9 keying rate", phase_out, 14'(hist[i-2]) << 12);
    end
    phase_sel = 2'd0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_load();
    logic [13:0] held;
    held = phase_out;
    wr(4'd4, 8'h04);
    repeat (4) @(negedge clk);
    chk("R2 staged has no effect", phase_out, held);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (4) @(negedge clk);
    check_step(14'd1, 4, "R5 step 1 (R1 feedback default on)");
  endtask

  task automatic t_wrap();
    load_ftw(48'h8000_0000_0000);
    check_step(14'h2000, 4, "R5 modulo wrap");
  endtask

  task automatic t_same_addr();
    load_ftw(48'h0);
    wr(4'd4, 8'h04);
    wr(4'd4, 8'h08);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (4) @(negedge clk);
    check_step(14'd1, 3, "R4 repeat dropped");
    wr(4'd4, 8'h08);
    wr(4'd5, 8'h00);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (4) @(negedge clk);
    check_step(14'd2, 3, "R4 other address taken");
  endtask

  task automatic t_collide();
    wr(4'd4, 8'h04);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd4; wr_data = 8'h10; upd = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; upd = 1'b0;
    repeat (4) @(negedge clk);
    check_step(14'd1, 3, "R3 strobe uses earlier byte");
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (4) @(negedge clk);
    check_step(14'd4, 3, "R3 later strobe picks up byte");
  endtask

  task automatic t_feedback();
    load_ftw(48'h0004_0000_0000);
    wr(4'd13, 8'h00);
    repeat (4) @(negedge clk);
    chk("R6 held at zero", phase_out, 14'h0);
    @(negedge clk);
    chk("R6 still zero", phase_out, 14'h0);
    wr(4'd13, 8'h20);
    chk("R6 restart +0", phase_out, 14'h0);
    @(negedge clk); chk("R6 restart +1", phase_out, 14'h0);
    @(negedge clk); chk("R6 restart +2", phase_out, 14'h0);
    @(negedge clk); chk("R6 restart +3", phase_out, 14'h1);
    @(negedge clk); chk("R6 restart +4", phase_out, 14'h2);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sel_latency();
    phase_sel = 2'd0;
    repeat (3) @(negedge clk);
    t_sel_rate();
    t_load();
    t_wrap();
    t_same_addr();
    t_collide();
    t_feedback();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule